// File: doc/BRIEF.md
# Lockable-Way Round-Robin Victim Selector

This block picks the way to evict when a set-associative cache misses. It keeps, for each set, a count of ways that are pinned in place and a rotating pointer. Pinned ways always fill the bottom of the set. Ways 0 up to count-1 are never evicted. The pointer walks only through the ways from the count up to the top way, so replacement stays round-robin over the free part of each set.

A miss request carries a set index. One cycle later the block returns the chosen way, and the pointer of that set moves on. A separate port writes the pinned-way count of one set at a time. A value above the allowed maximum is reduced to the maximum and reported. A flush input moves every pointer back to the first free way of its set and keeps the counts as they are. Tags, data arrays, hit detection and line fill are handled elsewhere.

Top module: `lrr_victim_sel`

## Requirements
- R1: After reset every set has a count of 0 and a pointer at way 0, so the first request to any set returns way 0. `vic_valid` and `lk_err` are low.
- R2: A count write stores min(`lk_count`, MAX_LOCK), with MAX_LOCK = 28. Each set therefore pins between 0 and 28 ways.
- R3: A returned way is never below the count of its set. Ways 0 to count-1 are the pinned ways.
- R4: Successive grants in one set return consecutive ways. After way 31 the next grant returns the first free way, which is way `count`.
- R5: `vic_valid` is high for exactly one cycle, in the cycle after a request that is granted, and `vic_way` holds the way during that cycle. A second request to the same set in the next cycle sees the advanced pointer.
- R6: A count write that raises the count above a set's pointer moves that pointer up to the new count. A write that lowers the count leaves the pointer where it is.
- R7: `lk_err` is high in the cycle after a count write whose value exceeds 28, and low otherwise.
- R8: Flush sets every pointer to the count of its set and keeps all counts. A request in the flush cycle is dropped, and no `vic_valid` follows it.
- R9: When a count write and a request hit the same set in the same cycle, the victim is chosen using the newly written count.
- R10: Sets are independent. Grants and count writes in one set do not change the pointer or count of any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Returns all pointers to each set's first free way |
| req_valid | input | 1 | Miss request strobe |
| req_set | input | 5 | Set index of the miss |
| vic_valid | output | 1 | Victim way valid, one cycle after a granted request |
| vic_way | output | 5 | Way to replace |
| lk_wr | input | 1 | Pinned-count write strobe |
| lk_set | input | 5 | Set whose count is written |
| lk_count | input | 6 | Requested pinned-way count |
| lk_err | output | 1 | Previous count write was above the maximum and was clamped |

## Verification
A count write and a miss request can land on the same set in the same cycle. The selection must then use the new count, and the pointer must end above the new pinned range. The bench forces this collision with directed cases: a write that raises the count past the pointer together with a request, and a write that lowers the count together with a request. It also steers the random requests and writes onto a handful of sets so that the collision occurs many times. A bench model, which applies the write before the selection, judges every returned way, and flush cycles that coincide with requests are checked to produce no grant.

// File: rtl/lrr_pkg.sv
package lrr_pkg;

  // Source of the next value for one set's round-robin pointer.
  typedef enum logic [1:0] {
    PTR_HOLD  = 2'd0,
    PTR_FLUSH = 2'd1,
    PTR_GRANT = 2'd2,
    PTR_LIFT  = 2'd3
  } ptr_src_e;

endpackage

// File: rtl/lrr_next_way.sv
module lrr_next_way #(
  parameter int NUM_WAYS = 32
) (
  input  logic [$clog2(NUM_WAYS)-1:0] ptr,
  input  logic [$clog2(NUM_WAYS)-1:0] cnt,
  output logic [$clog2(NUM_WAYS)-1:0] vic,
  output logic [$clog2(NUM_WAYS)-1:0] nxt
);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam logic [WAY_W-1:0] TOP_WAY = WAY_W'(NUM_WAYS - 1);

  // A pointer still inside the pinned range is moved to the first free way.
  always_comb begin
    vic = (ptr < cnt) ? cnt : ptr;
    nxt = (vic == TOP_WAY) ? cnt : vic + 1'b1;
  end
endmodule

// File: rtl/lrr_lock_table.sv
module lrr_lock_table #(
  parameter int NUM_SETS = 32,
  parameter int NUM_WAYS = 32,
  parameter int MAX_LOCK = 28
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  lk_wr,
  input  logic [$clog2(NUM_SETS)-1:0]           lk_set,
  input  logic [$clog2(NUM_WAYS+1)-1:0]         lk_count,
  output logic [$clog2(NUM_WAYS)-1:0]           wr_cnt,
  output logic [NUM_SETS*$clog2(NUM_WAYS)-1:0]  cnt_flat,
  output logic                                  lk_err
);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int CNT_W = $clog2(NUM_WAYS+1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(MAX_LOCK);

  logic over;

  always_comb begin
    over   = lk_count > LIM;
    wr_cnt = over ? WAY_W'(MAX_LOCK) : lk_count[WAY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) lk_err <= 1'b0;
    else     lk_err <= lk_wr && over;
  end

  AST_ERR_ON_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (lk_wr && lk_count > LIM) |=> lk_err); // R7
  AST_NO_FALSE_ERR: assert property (@(posedge clk) disable iff (rst)
    !(lk_wr && lk_count > LIM) |=> !lk_err); // R7

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_cnt
    logic [WAY_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst)                                    cnt_q <= '0;
      else if (lk_wr && lk_set == s[$clog2(NUM_SETS)-1:0]) cnt_q <= wr_cnt;
    end
    assign cnt_flat[s*WAY_W +: WAY_W] = cnt_q;

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= WAY_W'(MAX_LOCK)); // R2
  end
endmodule

// File: rtl/lrr_ptr_table.sv
module lrr_ptr_table
  import lrr_pkg::*;
#(
  parameter int NUM_SETS = 32,
  parameter int NUM_WAYS = 32
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  flush,
  input  logic                                  grant,
  input  logic [$clog2(NUM_SETS)-1:0]           req_set,
  input  logic [$clog2(NUM_WAYS)-1:0]           grant_nxt,
  input  logic                                  lk_wr,
  input  logic [$clog2(NUM_SETS)-1:0]           lk_set,
  input  logic [$clog2(NUM_WAYS)-1:0]           wr_cnt,
  input  logic [NUM_SETS*$clog2(NUM_WAYS)-1:0]  cnt_flat,
  output logic [NUM_SETS*$clog2(NUM_WAYS)-1:0]  ptr_flat
);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int SET_W = $clog2(NUM_SETS);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_ptr
    logic [WAY_W-1:0] ptr_q;
    logic [WAY_W-1:0] cnt_now;
    logic [WAY_W-1:0] cnt_after;
    logic             wr_here;
    ptr_src_e         src;

    always_comb begin
      cnt_now   = cnt_flat[s*WAY_W +: WAY_W];
      wr_here   = lk_wr && lk_set == SET_W'(s);
      cnt_after = wr_here ? wr_cnt : cnt_now;
      if (flush)                                  src = PTR_FLUSH;
      else if (grant && req_set == SET_W'(s))     src = PTR_GRANT;
      else if (wr_here && ptr_q < wr_cnt)         src = PTR_LIFT;
      else                                        src = PTR_HOLD;
    end

    always_ff @(posedge clk) begin
      if (rst) ptr_q <= '0;
      else begin
        unique case (src)
          PTR_FLUSH: ptr_q <= cnt_after;
          PTR_GRANT: ptr_q <= grant_nxt;
          PTR_LIFT:  ptr_q <= wr_cnt;
          default:   ptr_q <= ptr_q;
        endcase
      end
    end
    assign ptr_flat[s*WAY_W +: WAY_W] = ptr_q;

    AST_PTR_ABOVE_LOCK: assert property (@(posedge clk) disable iff (rst)
      ptr_q >= cnt_now); // R6
    AST_FLUSH_TO_FREE: assert property (@(posedge clk) disable iff (rst)
      flush |=> ptr_q == cnt_now); // R8
  end
endmodule

// File: rtl/lrr_victim_sel.sv
module lrr_victim_sel #(
  parameter int NUM_SETS = 32,
  parameter int NUM_WAYS = 32,
  parameter int MAX_LOCK = 28
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          req_valid,
  input  logic [$clog2(NUM_SETS)-1:0]   req_set,
  output logic                          vic_valid,
  output logic [$clog2(NUM_WAYS)-1:0]   vic_way,
  input  logic                          lk_wr,
  input  logic [$clog2(NUM_SETS)-1:0]   lk_set,
  input  logic [$clog2(NUM_WAYS+1)-1:0] lk_count,
  output logic                          lk_err
);
  localparam int WAY_W = $clog2(NUM_WAYS);

  logic [NUM_SETS*WAY_W-1:0] cnt_flat;
  logic [NUM_SETS*WAY_W-1:0] ptr_flat;
  logic [WAY_W-1:0]          wr_cnt;
  logic [WAY_W-1:0]          sel_ptr, sel_cnt, sel_vic, sel_nxt;
  logic                      grant;
  logic [WAY_W-1:0]          vic_cnt_q;

  lrr_lock_table #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .MAX_LOCK(MAX_LOCK)) u_lock (
    .clk(clk), .rst(rst), .lk_wr(lk_wr), .lk_set(lk_set), .lk_count(lk_count),
    .wr_cnt(wr_cnt), .cnt_flat(cnt_flat), .lk_err(lk_err)
  );

  // Same-set count write is forwarded into the selection of this cycle.
  always_comb begin
    grant   = req_valid && !flush;
    sel_ptr = ptr_flat[req_set*WAY_W +: WAY_W];
    sel_cnt = (lk_wr && lk_set == req_set) ? wr_cnt : cnt_flat[req_set*WAY_W +: WAY_W];
  end

  lrr_next_way #(.NUM_WAYS(NUM_WAYS)) u_next (
    .ptr(sel_ptr), .cnt(sel_cnt), .vic(sel_vic), .nxt(sel_nxt)
  );

  lrr_ptr_table #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_ptr (
    .clk(clk), .rst(rst), .flush(flush), .grant(grant), .req_set(req_set),
    .grant_nxt(sel_nxt), .lk_wr(lk_wr), .lk_set(lk_set), .wr_cnt(wr_cnt),
    .cnt_flat(cnt_flat), .ptr_flat(ptr_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vic_valid <= 1'b0;
      vic_way   <= '0;
      vic_cnt_q <= '0;
    end else begin
      vic_valid <= grant;
      if (grant) begin
        vic_way   <= sel_vic;
        vic_cnt_q <= sel_cnt;
      end
    end
  end

  AST_VIC_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    vic_valid |-> vic_way >= vic_cnt_q); // R3
  AST_GRANT_NEXT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !flush) |=> vic_valid); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !flush) |=> !vic_valid); // R8
endmodule

// File: tb/lrr_victim_sel_bench.sv
`timescale 1ns/1ps
module lrr_victim_sel_bench;
  localparam int MAXL = 28;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flush = 1'b0, req_valid = 1'b0, lk_wr = 1'b0;
  logic [4:0] req_set = '0, lk_set = '0;
  logic [5:0] lk_count = '0;
  logic       vic_valid, lk_err;
  logic [4:0] vic_way;

  lrr_victim_sel u_lrr_victim_sel (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid), .req_set(req_set),
    .vic_valid(vic_valid), .vic_way(vic_way), .lk_wr(lk_wr), .lk_set(lk_set),
    .lk_count(lk_count), .lk_err(lk_err)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  int m_cnt [32];
  int m_ptr [32];
  int e_vv = 0, e_way = 0, e_err = 0;
  string e_tag = "R1";

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int s = 0; s < 32; s++) begin m_cnt[s] = 0; m_ptr[s] = 0; end
  endfunction

  // One clock: check outputs caused by previous inputs, then drive and predict.
  task automatic cyc(string tag, bit fl, bit rv, int rs, bit lw, int ls, int lc);
    int nc;
    @(negedge clk);
    chk({e_tag, " vic_valid"}, int'(vic_valid), e_vv);
    if (e_vv != 0) chk({e_tag, " vic_way"}, int'(vic_way), e_way);
    chk("R7 lk_err", int'(lk_err), e_err);
    flush = fl; req_valid = rv; req_set = rs[4:0];
    lk_wr = lw; lk_set = ls[4:0]; lk_count = lc[5:0];
    nc    = (lc > MAXL) ? MAXL : lc;
    e_err = (lw && lc > MAXL) ? 1 : 0;
    e_tag = tag;
    e_vv  = 0;
    if (lw) begin
      m_cnt[ls] = nc;
      if (!fl && m_ptr[ls] < nc) m_ptr[ls] = nc;
    end
    if (fl) begin
      for (int s = 0; s < 32; s++) m_ptr[s] = m_cnt[s];
    end else if (rv) begin
      e_vv  = 1;
      e_way = m_ptr[rs];
      m_ptr[rs] = (e_way == 31) ? m_cnt[rs] : e_way + 1;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc("R1", 0, 0, 0, 0, 0, 0);
    // R1 / R5: fresh set, back-to-back
    cyc("R1", 0, 1, 3, 0, 0, 0);
    cyc("R5", 0, 1, 3, 0, 0, 0);
    cyc("R5", 0, 1, 3, 0, 0, 0);
    // R6 raise, R3/R4 rotation over 28..31
    cyc("R6", 0, 0, 0, 1, 5, 28);
    for (int i = 0; i < 5; i++) cyc("R4", 0, 1, 5, 0, 0, 0);
    cyc("R3", 0, 1, 5, 0, 0, 0);
    // R2 / R7 clamp
    cyc("R2", 0, 0, 0, 1, 7, 45);
    cyc("R2", 0, 1, 7, 0, 0, 0);
    cyc("R2", 0, 1, 7, 0, 0, 0);
    // R9 collision raising
    cyc("R9", 0, 1, 9, 1, 9, 10);
    cyc("R9", 0, 1, 9, 0, 0, 0);
    // R6 lowering: set 5 pointer at 30 now, lower count to 2
    cyc("R6", 0, 1, 5, 1, 5, 2);
    cyc("R6", 0, 1, 5, 0, 0, 0);
    // R10 other sets untouched
    cyc("R10", 0, 1, 3, 0, 0, 0);
    cyc("R10", 0, 1, 11, 0, 0, 0);
    // R8 flush with request dropped
    cyc("R8", 1, 1, 3, 0, 0, 0);
    cyc("R8", 0, 1, 3, 0, 0, 0);
    cyc("R8", 0, 1, 9, 0, 0, 0);
    cyc("R8", 0, 1, 7, 0, 0, 0);
    // random phase on few sets to provoke collisions
    for (int i = 0; i < 3000; i++) begin
      int rs = $urandom_range(0, 3);
      int ls = $urandom_range(0, 3);
      bit rv = ($urandom_range(0, 3) != 0);
      bit lw = ($urandom_range(0, 7) == 0);
      bit fl = ($urandom_range(0, 63) == 0);
      int lc = $urandom_range(0, 32);
      cyc((lw && rv && ls == rs) ? "R9" : "R4", fl, rv, rs, lw, ls, lc);
    end
    cyc("R5", 0, 0, 0, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule